// File: doc/BRIEF.md
# Column Command Spacing Checker

This block sits beside the command scheduler of a DDR5-style memory controller. Each cycle the scheduler presents one candidate column command: a read, a read with auto-precharge, a write or a write with auto-precharge, along with its rank, bank group, bank, burst length and a flag for narrow (x4) devices. The block answers with the earliest cycle, on its own free-running cycle counter, at which that command may legally go out. It also answers whether the command could go out in the cycle it was presented. When the scheduler does send the command, it raises the issue strobe with the same fields, and the block records that event.

Spacing is enforced at three scopes at once: the same bank, the same bank group and the same rank. For every command type and every scope, the block keeps the last issue cycle, the burst length and a valid bit. Read-to-read spacing, write-to-read turnaround and write-to-write spacing each have their own figure per scope. The write limits grow when the earlier write used a 32-beat burst. They also grow when the new write would force a read-modify-write, which happens on an x4 device with a 16-beat burst. The answer is the largest of all the terms that apply. Activate, refresh and rank-to-rank rules are handled elsewhere.

Top module: `col_cmd_timing`

## Requirements
- R1: After a synchronous active-high reset, no history exists: `earliest` reads 0, `ready` reads 1, and `cycle_count` restarts at 0.
- R2: Command codes are 0 read, 1 read with auto-precharge, 2 write, 3 write with auto-precharge. A query sampled at a clock edge with counter value k is answered after that edge. `earliest` is the maximum over all applicable terms, or 0 when none apply. `ready` is 1 exactly when k ≥ `earliest`. `cycle_count` advances by one per clock.
- R3: A read candidate waits 8 cycles (default) after an earlier read or read with auto-precharge. This holds at each of the three scopes: same bank, same bank group, same rank.
- R4: A read candidate waits WL + 8 + turnaround after an earlier write of either kind. The turnaround is 16 for the same bank, 16 for the same bank group and 4 for the same rank. WL defaults to 20.
- R5: If the earlier write used a 32-beat burst (`bl32`=1), 8 more cycles are added to every write-to-read term it produces. The same 8 cycles are added to the bank-scope and group-scope write-to-write terms it produces.
- R6: A write candidate waits after an earlier write to the same bank. The wait is 32 cycles when the candidate needs read-modify-write (`x4`=1 and `bl32`=0), and 16 cycles otherwise.
- R7: In the same bank group, a write candidate waits 32 cycles after a plain write. After a write with auto-precharge it waits 32 cycles if it needs read-modify-write, and 16 cycles otherwise.
- R8: In the same rank, a write candidate waits 8 cycles after any write, and the burst length of that write does not extend this wait.
- R9: Earlier reads never constrain a write candidate, and history in one rank never constrains a candidate in another rank.
- R10: A query presented in the same cycle as an issue strobe sees only the history from before that issue. The new entry is visible to the query in the next cycle.
- R11: A read with auto-precharge is constrained exactly like a read, and a write with auto-precharge exactly like a write. When either is the earlier command, it constrains a read candidate like its plain form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | The presented command is issued this cycle |
| cmd | input | 2 | Command code (see R2) |
| rank | input | RANK_BITS | Rank of the command |
| group | input | GROUP_BITS | Bank group of the command |
| bank | input | BANK_BITS | Bank within the group |
| bl32 | input | 1 | 1 = 32-beat burst, 0 = 16-beat burst |
| x4 | input | 1 | Device is x4 |
| earliest | output | TS_W | Earliest legal cycle for the last sampled query |
| ready | output | 1 | The last sampled query was legal in its own cycle |
| cycle_count | output | TS_W | Free-running cycle counter |

## Verification
Recording an issue and answering a query can fall in the same cycle, and usually hit the same history entries because the scheduler presents the command it sends. The bench provokes this with a directed case: it issues a read and queries that same bank in the same cycle, then expects an answer free of that read, followed by the full read spacing in the next cycle. The random phase draws from a deliberately small address space, so issues and queries collide often. There, each answer is judged against a model that applies an issue only after computing the expectation for that cycle.

// File: rtl/col_timing_pkg.sv
package col_timing_pkg;
  localparam int NCMD  = 4;
  localparam int NTIER = 3;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDA = 2'd1,
    CMD_WR  = 2'd2,
    CMD_WRA = 2'd3
  } col_cmd_e;

  localparam int TIER_BANK  = 0;
  localparam int TIER_GROUP = 1;
  localparam int TIER_RANK  = 2;

  function automatic logic cmd_is_write(input logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/col_hist_table.sv
module col_hist_table #(
  parameter int IW = 2,
  parameter int TW = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [1:0]                         wr_type,
  input  logic [IW-1:0]                      wr_idx,
  input  logic [TW-1:0]                      wr_ts,
  input  logic                               wr_bl32,
  input  logic [IW-1:0]                      rd_idx,
  output logic [col_timing_pkg::NCMD-1:0][TW-1:0] rd_ts,
  output logic [col_timing_pkg::NCMD-1:0]    rd_bl32,
  output logic [col_timing_pkg::NCMD-1:0]    rd_vld
);
  localparam int DEPTH = 1 << IW;

  for (genvar p = 0; p < col_timing_pkg::NCMD; p++) begin : g_type
    logic [TW:0]      mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic             hit;

    assign hit = wr_en && (wr_type == 2'(p));

    always_ff @(posedge clk) begin
      if (hit) mem[wr_idx] <= {wr_bl32, wr_ts};
    end

    always_ff @(posedge clk) begin
      if (rst)      vld <= '0;
      else if (hit) vld[wr_idx] <= 1'b1;
    end

    assign rd_ts[p]   = mem[rd_idx][TW-1:0];
    assign rd_bl32[p] = mem[rd_idx][TW];
    assign rd_vld[p]  = vld[rd_idx];
  end
endmodule

// File: rtl/col_rule_eval.sv
module col_rule_eval #(
  parameter int TW        = 32,
  parameter int WL        = 20,
  parameter int BURST     = 8,
  parameter int CCD_BANK  = 8,
  parameter int CCD_GRP   = 8,
  parameter int CCD_RANK  = 8,
  parameter int WTR_BANK  = 16,
  parameter int WTR_GRP   = 16,
  parameter int WTR_RANK  = 4,
  parameter int WW_RMW    = 32,
  parameter int WW_BANK   = 16,
  parameter int WW_GRP    = 32,
  parameter int WW_GRP_AP = 16,
  parameter int WW_RANK   = 8
) (
  input  logic cand_wr,
  input  logic cand_rmw,
  input  logic [col_timing_pkg::NTIER-1:0][col_timing_pkg::NCMD-1:0][TW-1:0] h_ts,
  input  logic [col_timing_pkg::NTIER-1:0][col_timing_pkg::NCMD-1:0]         h_bl32,
  input  logic [col_timing_pkg::NTIER-1:0][col_timing_pkg::NCMD-1:0]         h_vld,
  output logic [TW-1:0] earliest
);
  import col_timing_pkg::*;

  function automatic int ccd_of(input int t);
    case (t)
      TIER_BANK:  return CCD_BANK;
      TIER_GROUP: return CCD_GRP;
      default:    return CCD_RANK;
    endcase
  endfunction

  function automatic int wtr_of(input int t);
    case (t)
      TIER_BANK:  return WTR_BANK;
      TIER_GROUP: return WTR_GRP;
      default:    return WTR_RANK;
    endcase
  endfunction

  function automatic int gap(input int t, input int p, input logic cw,
                             input logic rmw, input logic b32);
    int ext;
    ext = b32 ? BURST : 0;
    if (!cw) begin
      if (p < 2) return ccd_of(t);
      return WL + BURST + wtr_of(t) + ext;
    end
    case (t)
      TIER_BANK:  return (rmw ? WW_RMW : WW_BANK) + ext;
      TIER_GROUP: return ((p == int'(CMD_WR)) ? WW_GRP : (rmw ? WW_GRP : WW_GRP_AP)) + ext;
      default:    return WW_RANK;
    endcase
  endfunction

  always_comb begin
    logic [TW-1:0] term;
    earliest = '0;
    for (int t = 0; t < NTIER; t++) begin
      for (int p = 0; p < NCMD; p++) begin
        term = '0;
        if (h_vld[t][p] && !(cand_wr && p < 2))
          term = h_ts[t][p] + TW'(gap(t, p, cand_wr, cand_rmw, h_bl32[t][p]));
        if (term > earliest) earliest = term;
      end
    end
  end
endmodule

// File: rtl/col_cmd_timing.sv
module col_cmd_timing #(
  parameter int RANK_BITS  = 1,
  parameter int GROUP_BITS = 3,
  parameter int BANK_BITS  = 2,
  parameter int TS_W       = 32,
  parameter int WL         = 20,
  parameter int BURST      = 8,
  parameter int CCD_BANK   = 8,
  parameter int CCD_GRP    = 8,
  parameter int CCD_RANK   = 8,
  parameter int WTR_BANK   = 16,
  parameter int WTR_GRP    = 16,
  parameter int WTR_RANK   = 4,
  parameter int WW_RMW     = 32,
  parameter int WW_BANK    = 16,
  parameter int WW_GRP     = 32,
  parameter int WW_GRP_AP  = 16,
  parameter int WW_RANK    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic [1:0]            cmd,
  input  logic [RANK_BITS-1:0]  rank,
  input  logic [GROUP_BITS-1:0] group,
  input  logic [BANK_BITS-1:0]  bank,
  input  logic                  bl32,
  input  logic                  x4,
  output logic [TS_W-1:0]       earliest,
  output logic                  ready,
  output logic [TS_W-1:0]       cycle_count
);
  import col_timing_pkg::*;

  localparam int IW_BANK  = RANK_BITS + GROUP_BITS + BANK_BITS;
  localparam int IW_GROUP = RANK_BITS + GROUP_BITS;
  localparam int IW_RANK  = RANK_BITS;

  logic [NTIER-1:0][NCMD-1:0][TS_W-1:0] h_ts;
  logic [NTIER-1:0][NCMD-1:0]           h_bl32;
  logic [NTIER-1:0][NCMD-1:0]           h_vld;
  logic [TS_W-1:0]                      earl_c;
  logic                                 rec_en;

  assign rec_en = issue && !rst;

  for (genvar t = 0; t < NTIER; t++) begin : g_tier
    localparam int IW = (t == TIER_BANK) ? IW_BANK :
                        (t == TIER_GROUP) ? IW_GROUP : IW_RANK;
    logic [IW-1:0]               idx;
    logic [NCMD-1:0][TS_W-1:0]   t_ts;
    logic [NCMD-1:0]             t_bl;
    logic [NCMD-1:0]             t_vld;

    if (t == TIER_BANK) begin : g_ib
      assign idx = {rank, group, bank};
    end else if (t == TIER_GROUP) begin : g_ig
      assign idx = {rank, group};
    end else begin : g_ir
      assign idx = rank;
    end

    col_hist_table #(.IW(IW), .TW(TS_W)) u_tab (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (rec_en),
      .wr_type (cmd),
      .wr_idx  (idx),
      .wr_ts   (cycle_count),
      .wr_bl32 (bl32),
      .rd_idx  (idx),
      .rd_ts   (t_ts),
      .rd_bl32 (t_bl),
      .rd_vld  (t_vld)
    );

    assign h_ts[t]   = t_ts;
    assign h_bl32[t] = t_bl;
    assign h_vld[t]  = t_vld;
  end

  col_rule_eval #(
    .TW(TS_W), .WL(WL), .BURST(BURST),
    .CCD_BANK(CCD_BANK), .CCD_GRP(CCD_GRP), .CCD_RANK(CCD_RANK),
    .WTR_BANK(WTR_BANK), .WTR_GRP(WTR_GRP), .WTR_RANK(WTR_RANK),
    .WW_RMW(WW_RMW), .WW_BANK(WW_BANK), .WW_GRP(WW_GRP),
    .WW_GRP_AP(WW_GRP_AP), .WW_RANK(WW_RANK)
  ) u_eval (
    .cand_wr  (cmd_is_write(cmd)),
    .cand_rmw (x4 && !bl32),
    .h_ts     (h_ts),
    .h_bl32   (h_bl32),
    .h_vld    (h_vld),
    .earliest (earl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_count <= '0;
      earliest    <= '0;
      ready       <= 1'b1;
    end else begin
      cycle_count <= cycle_count + 1'b1;
      earliest    <= earl_c;
      ready       <= (cycle_count >= earl_c);
    end
  end
endmodule

// File: rtl/col_cmd_timing_chk.sv
module col_cmd_timing_chk #(
  parameter int RANK_BITS  = 1,
  parameter int GROUP_BITS = 3,
  parameter int BANK_BITS  = 2,
  parameter int TS_W       = 32,
  parameter int WL         = 20,
  parameter int BURST      = 8,
  parameter int CCD_BANK   = 8,
  parameter int WTR_RANK   = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  issue,
  input logic [1:0]            cmd,
  input logic [RANK_BITS-1:0]  rank,
  input logic [GROUP_BITS-1:0] group,
  input logic [BANK_BITS-1:0]  bank,
  input logic [TS_W-1:0]       earliest,
  input logic                  ready,
  input logic [TS_W-1:0]       cycle_count
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (earliest == '0 && ready && cycle_count == '0));

  assert_ready_relation_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ready == ($past(cycle_count) >= earliest)));

  assert_counter_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cycle_count == $past(cycle_count) + 1'b1));

  assert_rd_rd_bank_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue) && !$past(cmd[1]) && !cmd[1] &&
     rank == $past(rank) && group == $past(group) && bank == $past(bank))
    |=> (earliest >= $past(cycle_count, 2) + TS_W'(CCD_BANK)));

  assert_wr_rd_rank_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue) && $past(cmd[1]) && !cmd[1] && rank == $past(rank))
    |=> (earliest >= $past(cycle_count, 2) + TS_W'(WL + BURST + WTR_RANK)));
endmodule

bind col_cmd_timing col_cmd_timing_chk #(
  .RANK_BITS(RANK_BITS), .GROUP_BITS(GROUP_BITS), .BANK_BITS(BANK_BITS),
  .TS_W(TS_W), .WL(WL), .BURST(BURST), .CCD_BANK(CCD_BANK), .WTR_RANK(WTR_RANK)
) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .cmd(cmd), .rank(rank), .group(group),
  .bank(bank), .earliest(earliest), .ready(ready), .cycle_count(cycle_count)
);

// File: tb/col_cmd_timing_tb.sv
`timescale 1ns/1ps
module col_cmd_timing_tb;
  localparam int WL = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [0:0]  rank = '0;
  logic [2:0]  grp = '0;
  logic [1:0]  bank = '0;
  logic        bl32 = 1'b0;
  logic        x4 = 1'b0;
  logic [31:0] earliest;
  logic        ready;
  logic [31:0] cycle_count;

  int n_checks = 0;
  int n_errors = 0;
  int last_k = 0;
  bit done = 0;

  int m_ts [3][4][64];
  bit m_bl [3][4][64];
  bit m_v  [3][4][64];

  always #2.5 clk = ~clk;

  col_cmd_timing u_dut (
    .clk(clk), .rst(rst), .issue(issue), .cmd(cmd), .rank(rank), .group(grp),
    .bank(bank), .bl32(bl32), .x4(x4), .earliest(earliest), .ready(ready),
    .cycle_count(cycle_count)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint exp_e(int c, int r, int g, int b, bit b32, bit x4v);
    longint e = 0;
    longint term;
    int ix [3];
    bit cw = (c >= 2);
    bit rmw = x4v && !b32;
    int ext;
    ix[0] = r * 32 + g * 4 + b;
    ix[1] = r * 8 + g;
    ix[2] = r;
    for (int t = 0; t < 3; t++) begin
      for (int p = 0; p < 4; p++) begin
        if (!m_v[t][p][ix[t]]) continue;
        if (cw && p < 2) continue;
        ext = m_bl[t][p][ix[t]] ? 8 : 0;
        if (!cw) term = m_ts[t][p][ix[t]] + ((p < 2) ? 8 : WL + 8 + ((t == 2) ? 4 : 16) + ext);
        else if (t == 0) term = m_ts[t][p][ix[t]] + (rmw ? 32 : 16) + ext;
        else if (t == 1) term = m_ts[t][p][ix[t]] + ((p == 2 || rmw) ? 32 : 16) + ext;
        else term = m_ts[t][p][ix[t]] + 8;
        if (term > e) e = term;
      end
    end
    return e;
  endfunction

  task automatic step(input bit iss, input int c, input int r, input int g, input int b,
                      input bit b32, input bit x4v, input string tag);
    longint e;
    int k;
    int ix [3];
    issue = iss; cmd = 2'(c); rank = 1'(r); grp = 3'(g); bank = 2'(b);
    bl32 = b32; x4 = x4v;
    k = int'(cycle_count);
    e = exp_e(c, r, g, b, b32, x4v);
    @(posedge clk);
    #1;
    if (iss) begin
      ix[0] = r * 32 + g * 4 + b;
      ix[1] = r * 8 + g;
      ix[2] = r;
      for (int t = 0; t < 3; t++) begin
        m_ts[t][c][ix[t]] = k;
        m_bl[t][c][ix[t]] = b32;
        m_v[t][c][ix[t]]  = 1'b1;
      end
    end
    @(negedge clk);
    issue = 1'b0;
    chk(tag, longint'(earliest), e);
    chk(tag, longint'(ready), (longint'(k) >= e) ? 1 : 0);
    last_k = k;
  endtask

  task automatic dchk(input string tag, input longint exp);
    chk(tag, longint'(earliest), exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    issue = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 3; t++)
      for (int p = 0; p < 4; p++)
        for (int i = 0; i < 64; i++) m_v[t][p][i] = 1'b0;
    chk("R1 earliest", longint'(earliest), 0);
    chk("R1 ready", longint'(ready), 1);
    chk("R1 counter", longint'(cycle_count), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int ts;
    int c, r, g, b;
    void'($urandom(1234));
    @(negedge clk);

    // R3: read spacing at bank, group and rank scope
    do_reset();
    step(1, 0, 0, 0, 0, 0, 0, "R3"); ts = last_k;
    step(0, 0, 0, 0, 0, 0, 0, "R3"); dchk("R3 bank", ts + 8);
    step(0, 0, 0, 0, 1, 0, 0, "R3"); dchk("R3 group", ts + 8);
    step(0, 0, 0, 1, 0, 0, 0, "R3"); dchk("R3 rank", ts + 8);

    // R4: write-to-read turnaround
    do_reset();
    step(1, 2, 0, 0, 0, 0, 0, "R4"); ts = last_k;
    step(0, 0, 0, 0, 0, 0, 0, "R4"); dchk("R4 bank", ts + 44);
    step(0, 0, 0, 0, 1, 0, 0, "R4"); dchk("R4 group", ts + 44);
    step(0, 0, 0, 1, 0, 0, 0, "R4"); dchk("R4 rank", ts + 32);

    // R5: 32-beat prior write stretches the terms
    do_reset();
    step(1, 2, 0, 0, 0, 1, 0, "R5"); ts = last_k;
    step(0, 0, 0, 0, 0, 0, 0, "R5"); dchk("R5 rd bank", ts + 52);
    step(0, 0, 0, 1, 0, 0, 0, "R5"); dchk("R5 rd rank", ts + 40);
    step(0, 2, 0, 0, 0, 0, 1, "R5"); dchk("R5 wr bank rmw", ts + 40);

    // R6: same-bank write spacing with and without read-modify-write
    do_reset();
    step(1, 3, 0, 0, 0, 0, 0, "R6"); ts = last_k;
    step(0, 2, 0, 0, 0, 0, 0, "R6"); dchk("R6 x8", ts + 16);
    step(0, 2, 0, 0, 0, 0, 1, "R6"); dchk("R6 x4 bl16", ts + 32);
    step(0, 2, 0, 0, 0, 1, 1, "R6"); dchk("R6 x4 bl32", ts + 16);

    // R7 / R8: group and rank write spacing
    do_reset();
    step(1, 2, 0, 0, 0, 0, 0, "R7"); ts = last_k;
    step(0, 2, 0, 0, 1, 0, 0, "R7"); dchk("R7 group after wr", ts + 32);
    step(0, 2, 0, 1, 0, 0, 0, "R8"); dchk("R8 rank", ts + 8);
    do_reset();
    step(1, 3, 0, 2, 0, 0, 0, "R7"); ts = last_k;
    step(0, 2, 0, 2, 1, 0, 0, "R7"); dchk("R7 group after wra", ts + 16);
    step(0, 2, 0, 2, 1, 0, 1, "R7"); dchk("R7 group after wra rmw", ts + 32);
    do_reset();
    step(1, 2, 0, 0, 0, 1, 0, "R8"); ts = last_k;
    step(0, 2, 0, 1, 0, 0, 0, "R8"); dchk("R8 no bl32 stretch", ts + 8);

    // R9: reads do not hold writes; ranks are isolated
    do_reset();
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 2, 0, 0, 0, 0, 0, "R9"); dchk("R9 rd vs wr", 0);
    step(1, 2, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, 0, "R9"); dchk("R9 other rank", 0);
    chk("R9 ready", longint'(ready), 1);

    // R10: issue and query in the same cycle
    do_reset();
    step(1, 0, 0, 3, 2, 0, 0, "R10"); ts = last_k;
    dchk("R10 same cycle", 0);
    step(0, 0, 0, 3, 2, 0, 0, "R10"); dchk("R10 next cycle", ts + 8);

    // R11: auto-precharge variants
    do_reset();
    step(1, 3, 0, 0, 0, 0, 0, "R11"); ts = last_k;
    step(0, 1, 0, 0, 0, 0, 0, "R11"); dchk("R11 rda after wra", ts + 44);
    step(1, 1, 1, 0, 0, 0, 0, "R11"); ts = last_k;
    step(0, 0, 1, 0, 0, 0, 0, "R11"); dchk("R11 rd after rda", ts + 8);

    // R2: ready rises exactly at the earliest cycle
    do_reset();
    step(1, 0, 1, 2, 3, 0, 0, "R2"); ts = last_k;
    for (int i = 0; i < 10; i++) begin
      step(0, 0, 1, 2, 3, 0, 0, "R2");
      chk("R2 ready edge", longint'(ready), (last_k >= ts + 8) ? 1 : 0);
    end

    // R2: random mix against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      c = int'($urandom_range(0, 3));
      r = int'($urandom_range(0, 1));
      g = int'($urandom_range(0, 1));
      b = int'($urandom_range(0, 1));
      step(($urandom_range(0, 3) == 0), c, r, g, b,
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule